// File: doc/BRIEF.md
# UART Modem Control and Loopback Router

This block holds the eight-bit modem control register of a UART and routes the serial and modem signals between the UART core and the device pins. A byte-wide bus port writes the register. The read path always returns the current register value. The register selects several things: line polarity inversion, a multidrop mode flag that goes to the core, the four modem control outputs, and an internal loopback mode.

In normal operation the serial output and input pass between the core and the pins. They are optionally inverted. The active-low modem status pins are presented to the core as active-high status bits, and the control bits drive active-low output pins. In loopback the block isolates the pins. The serial output pin idles high, and transmit data returns directly to the core's receive input. The four control bits come back to the core as the four status bits, and every control output pin goes to its inactive (high) level.

Top module: `uart_mcr_loop`

## Requirements
- R1: After reset the register reads 0x00, the serial output pin follows the core transmit data unchanged, and multidrop is 0.
- R2: Bit 7 of the register always reads 0, whatever value is written to it.
- R3: Bits 6..0 are read/write and read back exactly the value last written.
- R4: With loopback off and bit 6 (polarity) set, the serial output pin is the inverse of the core transmit data, and the core receive data is the inverse of the serial input pin. With bit 6 clear, both pass unchanged.
- R5: The multidrop output equals register bit 5.
- R6: With bit 4 (loopback) set, the serial output pin is 1 whatever the polarity bit is. The core receive data equals the core transmit data, with no inversion.
- R7: With loopback set, the external status pins are ignored. The core sees DCD = bit 3, RI = bit 2, CTS = bit 1 and DSR = bit 0.
- R8: With loopback set, the pins rtsN, dtrN, out1N and out2N are all 1.
- R9: With loopback off, each status bit to the core is the inverse of its active-low pin. Bits 3 and 2 do not affect the status bits. The output pins are out2N = ~bit3, out1N = ~bit2, rtsN = ~bit1 and dtrN = ~bit0.
- R10: A register write takes effect on the clock edge where wrEn is sampled high. Its read value and its routing effects are visible in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Current register value |
| coreTxd | input | 1 | Transmit data from the UART core |
| coreRxd | output | 1 | Receive data to the UART core |
| txPin | output | 1 | Serial output pin |
| rxPin | input | 1 | Serial input pin |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| dcdN | input | 1 | Carrier-detect pin, active low |
| riN | input | 1 | Ring-indicator pin, active low |
| stCts | output | 1 | CTS status to core |
| stDsr | output | 1 | DSR status to core |
| stDcd | output | 1 | DCD status to core |
| stRi | output | 1 | RI status to core |
| rtsN | output | 1 | Request-to-send pin, active low |
| dtrN | output | 1 | Data-terminal-ready pin, active low |
| out1N | output | 1 | General output 1 pin, active low |
| out2N | output | 1 | General output 2 pin, active low |
| multidrop | output | 1 | Multidrop mode flag to core |

## Verification
The hardest situation to reach is loopback with the polarity bit set and the external pins driven to values that disagree with the control bits. Only that combination shows whether the loop path skips the inverter and whether the pins are truly disconnected. The stimulus first writes the register with loopback, polarity and a chosen control pattern. It then drives every status pin and the serial input opposite to the expected looped value and toggles the core transmit data. Further writes change only the control bits, so each status bit can be traced to its source bit.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;
  localparam int REG_W = 8;
  localparam int BIT_POL = 6;
  localparam int BIT_MDROP = 5;
  localparam int BIT_LOOP = 4;
  localparam int BIT_OUT2 = 3;
  localparam int BIT_OUT1 = 2;
  localparam int BIT_RTS = 1;
  localparam int BIT_DTR = 0;
  localparam int USED_W = BIT_POL + 1;

  typedef struct packed {
    logic pol;
    logic mdrop;
    logic loop;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
  } mcrCtl_t;
endpackage

// File: rtl/uart_mcr_ctrl.sv
module uart_mcr_ctrl
  import uart_mcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output mcrCtl_t          ctl
);
  logic [USED_W-1:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else if (wrEn) regQ <= wrData[USED_W-1:0];
  end

  assign rdData = {{(REG_W-USED_W){1'b0}}, regQ};

  assign ctl.pol   = regQ[BIT_POL];
  assign ctl.mdrop = regQ[BIT_MDROP];
  assign ctl.loop  = regQ[BIT_LOOP];
  assign ctl.out2  = regQ[BIT_OUT2];
  assign ctl.out1  = regQ[BIT_OUT1];
  assign ctl.rts   = regQ[BIT_RTS];
  assign ctl.dtr   = regQ[BIT_DTR];

  // R2: reserved bit never reads as 1
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1] == 1'b0);

  // R10: a write is visible in the following cycle
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[USED_W-1:0] == $past(wrData[USED_W-1:0]));

  // R3: without a write the register holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));
endmodule

// File: rtl/uart_mcr_path.sv
module uart_mcr_path
  import uart_mcr_pkg::*;
(
  input  mcrCtl_t ctl,
  input  logic    clk,
  input  logic    rstN,
  input  logic    coreTxd,
  output logic    coreRxd,
  output logic    txPin,
  input  logic    rxPin,
  input  logic    ctsN,
  input  logic    dsrN,
  input  logic    dcdN,
  input  logic    riN,
  output logic    stCts,
  output logic    stDsr,
  output logic    stDcd,
  output logic    stRi,
  output logic    rtsN,
  output logic    dtrN,
  output logic    out1N,
  output logic    out2N,
  output logic    multidrop
);
  always_comb begin
    if (ctl.loop) begin
      txPin   = 1'b1;
      coreRxd = coreTxd;
      stCts   = ctl.rts;
      stDsr   = ctl.dtr;
      stDcd   = ctl.out2;
      stRi    = ctl.out1;
      rtsN    = 1'b1;
      dtrN    = 1'b1;
      out1N   = 1'b1;
      out2N   = 1'b1;
    end else begin
      txPin   = coreTxd ^ ctl.pol;
      coreRxd = rxPin ^ ctl.pol;
      stCts   = ~ctsN;
      stDsr   = ~dsrN;
      stDcd   = ~dcdN;
      stRi    = ~riN;
      rtsN    = ~ctl.rts;
      dtrN    = ~ctl.dtr;
      out1N   = ~ctl.out1;
      out2N   = ~ctl.out2;
    end
  end

  assign multidrop = ctl.mdrop;

  // R6: the serial output idles high in loopback
  a_r6_tx_idle: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loop |-> txPin);

  // R6: loop path carries no inversion
  a_r6_loop_data: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loop |-> coreRxd == coreTxd);

  // R8: all control pins inactive in loopback
  a_r8_pins_inactive: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loop |-> (rtsN && dtrN && out1N && out2N));

  // R9: general outputs never touch status in normal mode
  a_r9_status_from_pins: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loop |-> (stDcd != dcdN) && (stRi != riN));
endmodule

// File: rtl/uart_mcr_loop.sv
module uart_mcr_loop
  import uart_mcr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             coreTxd,
  output logic             coreRxd,
  output logic             txPin,
  input  logic             rxPin,
  input  logic             ctsN,
  input  logic             dsrN,
  input  logic             dcdN,
  input  logic             riN,
  output logic             stCts,
  output logic             stDsr,
  output logic             stDcd,
  output logic             stRi,
  output logic             rtsN,
  output logic             dtrN,
  output logic             out1N,
  output logic             out2N,
  output logic             multidrop
);
  mcrCtl_t ctl;

  uart_mcr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .ctl(ctl)
  );

  uart_mcr_path uPath (
    .ctl(ctl), .clk(clk), .rstN(rstN),
    .coreTxd(coreTxd), .coreRxd(coreRxd), .txPin(txPin), .rxPin(rxPin),
    .ctsN(ctsN), .dsrN(dsrN), .dcdN(dcdN), .riN(riN),
    .stCts(stCts), .stDsr(stDsr), .stDcd(stDcd), .stRi(stRi),
    .rtsN(rtsN), .dtrN(dtrN), .out1N(out1N), .out2N(out2N),
    .multidrop(multidrop)
  );
endmodule

// File: tb/tb_uart_mcr_loop.sv
module tb_uart_mcr_loop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic coreTxd = 1'b0, rxPin = 1'b1;
  logic ctsN = 1'b1, dsrN = 1'b1, dcdN = 1'b1, riN = 1'b1;
  logic coreRxd, txPin, stCts, stDsr, stDcd, stRi;
  logic rtsN, dtrN, out1N, out2N, multidrop;
  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_mcr_loop dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tReset();
    check("R1 reset value", rdData, 8'h00);
    coreTxd = 1'b1; #1;
    check("R1 tx passes", {7'b0, txPin}, 8'h01);
    coreTxd = 1'b0; #1;
    check("R1 tx passes low", {7'b0, txPin}, 8'h00);
    check("R1 multidrop", {7'b0, multidrop}, 8'h00);
  endtask

  task automatic tRegAccess();
    writeReg(8'hFF);
    check("R2 bit7 reads 0", rdData, 8'h7F);
    writeReg(8'h2A);
    check("R3 readback 2A", rdData, 8'h2A);
    writeReg(8'h85);
    check("R2 R3 readback 85", rdData, 8'h05);
  endtask

  task automatic tWriteTiming();
    @(negedge clk);
    wrEn = 1'b1; wrData = 8'h03;
    #1 check("R10 no change before edge", rdData, 8'h05);
    @(negedge clk);
    wrEn = 1'b0;
    check("R10 value after edge", rdData, 8'h03);
    check("R10 rtsN/dtrN after edge", {6'b0, rtsN, dtrN}, 8'h00);
  endtask

  task automatic tPolarity();
    writeReg(8'h00);
    for (int i = 0; i < 2; i++) begin
      coreTxd = i[0]; rxPin = ~i[0]; #1;
      check("R4 tx normal", {7'b0, txPin}, {7'b0, i[0]});
      check("R4 rx normal", {7'b0, coreRxd}, {7'b0, ~i[0]});
    end
    writeReg(8'h40);
    for (int i = 0; i < 2; i++) begin
      coreTxd = i[0]; rxPin = i[0]; #1;
      check("R4 tx inverted", {7'b0, txPin}, {7'b0, ~i[0]});
      check("R4 rx inverted", {7'b0, coreRxd}, {7'b0, ~i[0]});
    end
  endtask

  task automatic tMultidrop();
    writeReg(8'h20);
    check("R5 multidrop on", {7'b0, multidrop}, 8'h01);
    writeReg(8'h5F);
    check("R5 multidrop off", {7'b0, multidrop}, 8'h00);
  endtask

  task automatic tLoopData();
    writeReg(8'h50);
    rxPin = 1'b0;
    for (int i = 0; i < 2; i++) begin
      coreTxd = i[0]; rxPin = ~i[0]; #1;
      check("R6 tx pin high", {7'b0, txPin}, 8'h01);
      check("R6 loop data", {7'b0, coreRxd}, {7'b0, i[0]});
    end
  endtask

  task automatic tLoopStatus();
    logic [3:0] pats [4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};
    foreach (pats[k]) begin
      writeReg({4'b0001, pats[k]});
      ctsN = pats[k][1]; dsrN = pats[k][0]; dcdN = pats[k][3]; riN = pats[k][2];
      #1;
      check("R7 loop status dcd,ri,cts,dsr", {4'b0, stDcd, stRi, stCts, stDsr}, {4'b0, pats[k]});
      check("R8 pins inactive", {4'b0, out2N, out1N, rtsN, dtrN}, 8'h0F);
    end
  endtask

  task automatic tNormalStatus();
    writeReg(8'h0C);
    ctsN = 1'b0; dsrN = 1'b1; dcdN = 1'b1; riN = 1'b1; #1;
    check("R9 status from pins", {4'b0, stDcd, stRi, stCts, stDsr}, 8'h02);
    check("R9 output pins", {4'b0, out2N, out1N, rtsN, dtrN}, 8'h03);
    writeReg(8'h03);
    ctsN = 1'b1; dsrN = 1'b1; dcdN = 1'b0; riN = 1'b0; #1;
    check("R9 status from pins 2", {4'b0, stDcd, stRi, stCts, stDsr}, 8'h0C);
    check("R9 output pins 2", {4'b0, out2N, out1N, rtsN, dtrN}, 8'h0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegAccess();
    tWriteTiming();
    tPolarity();
    tMultidrop();
    tLoopData();
    tLoopStatus();
    tNormalStatus();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule